// File: doc/BRIEF.md
# Overlapped Register Window File

This block is a processor register file that gives each procedure its own view of 32 logical registers. Those views are carved out of a smaller pool of 74 physical registers. Ten registers are global and look the same from every window. The remaining 64 registers form four windows arranged in a ring. Each window owns ten private registers. It shares six registers with the window before it and six with the window after it. The last window in the ring shares with the first.

A window pointer selects which physical registers the logical numbers reach. A call strobe moves the pointer one window forward. The caller's outgoing registers then reappear as the callee's incoming registers, so parameters and results pass between the two procedures without any copying. A return strobe moves the pointer one window back.

A depth counter tracks how many calls are still open. A call made when every window is in use is refused and raises an overflow pulse. A return made with no open call is refused and raises an underflow pulse. Spilling windows to memory is left to the surrounding logic. The file has two combinational read ports and one clocked write port, all addressed by 5-bit logical register numbers.

Top module: `rwin_file`

## Requirements
- R1: While reset is low, and after it is released, both read ports return 0 for every logical register, the window pointer is 0, the depth is 0, and both flags are 0.
- R2: Logical registers 0 to 9 map to the same physical register whatever the window pointer is. A value written to one of them in one window reads back unchanged in every other window.
- R3: Logical registers 16 to 25 are private to each window. A write to one of them in window w cannot be seen through logical 16 to 25 of any other window.
- R4: Logical registers 26 to 31 of window w are the same physical registers as logical registers 10 to 15 of window (w+1) mod 4, in the same order. This includes the pairing of window 3 with window 0.
- R5: A call with depth below 3 sets the window pointer to (pointer+1) mod 4 and adds one to the depth at the next rising edge. The window pointer always equals the depth.
- R6: A return with depth above 0 takes one from both the window pointer and the depth at the next rising edge.
- R7: A call at depth 3 leaves the pointer and the depth unchanged. The overflow flag is then high for exactly the one cycle that follows that edge.
- R8: A return at depth 0 leaves the pointer and the depth unchanged. The underflow flag is then high for exactly the one cycle that follows that edge.
- R9: A write takes effect at the rising edge. It lands in the physical register chosen by the window pointer held before that edge, even when a call or return is applied in the same cycle.
- R10: When call and return are both high in the same cycle, the window pointer, the depth and both flags stay as they are.
- R11: The two read ports are combinational and independent of each other. A value written at an edge is visible on either port right after that edge, and both ports may address the same register at once.
- R12: With the write enable low, the write address and the write data change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| call_i | input | 1 | Advance to the next window |
| ret_i | input | 1 | Go back to the previous window |
| rd_a_addr | input | 5 | Logical register number for read port A |
| rd_a_data | output | 32 | Contents of the register addressed on port A |
| rd_b_addr | input | 5 | Logical register number for read port B |
| rd_b_data | output | 32 | Contents of the register addressed on port B |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Logical register number to write |
| wr_data | input | 32 | Value to write |
| cwp_o | output | 2 | Current window pointer |
| depth_o | output | 2 | Number of calls still open |
| ovf_o | output | 1 | One-cycle pulse after a refused call |
| unf_o | output | 1 | One-cycle pulse after a refused return |

## Verification
The assertions assume that call and return are synchronous levels sampled once per rising edge, and that any 5-bit logical number is a legal address. They also assume that call and return may be high together, in which case the block does nothing. The stimulus changes inputs only on falling edges. It walks the pointer up to the deepest window and back down to the root, so that both refused moves are provoked from a legal state. The wrap from window 3 to window 0 is checked only through a value written at depth 3 and then read back at depth 0.

// File: rtl/rwin_pkg.sv
package rwin_pkg;
  localparam int RW_NGLOB  = 10;
  localparam int RW_NLOC   = 10;
  localparam int RW_NCOM   = 6;
  localparam int RW_NWIN   = 4;
  localparam int RW_DATA_W = 32;

  typedef enum logic [2:0] {
    WM_HOLD,
    WM_CALL,
    WM_RET,
    WM_OVF,
    WM_UNF
  } wmove_e;
endpackage

// File: rtl/rwin_xlate.sv
module rwin_xlate #(
  parameter int NGLOB  = 10,
  parameter int NLOC   = 10,
  parameter int NCOM   = 6,
  parameter int NWIN   = 4,
  parameter int LREG_W = 5,
  parameter int PHYS_W = 7,
  parameter int CWP_W  = 2
) (
  input  logic [CWP_W-1:0]  cwp,
  input  logic [LREG_W-1:0] lreg,
  output logic [PHYS_W-1:0] phys
);
  localparam int STRIDE   = NLOC + NCOM;
  localparam int OUT_BASE = NGLOB + NCOM + NLOC;

  // Incoming set and locals are contiguous inside a window's slice;
  // the outgoing set is the incoming set of the following window.
  function automatic logic [PHYS_W-1:0] f_phys(input logic [CWP_W-1:0] w,
                                               input logic [LREG_W-1:0] r);
    int ri;
    int wi;
    int nx;
    int p;
    ri = int'(r);
    wi = int'(w);
    nx = (wi + 1) % NWIN;
    if (ri < NGLOB)
      p = ri;
    else if (ri < OUT_BASE)
      p = NGLOB + wi * STRIDE + (ri - NGLOB);
    else
      p = NGLOB + nx * STRIDE + (ri - OUT_BASE);
    return p[PHYS_W-1:0];
  endfunction

  assign phys = f_phys(cwp, lreg);
endmodule

// File: rtl/rwin_ctrl.sv
module rwin_ctrl
  import rwin_pkg::*;
#(
  parameter int NWIN  = 4,
  parameter int CWP_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             call_i,
  input  logic             ret_i,
  output wmove_e           win_move,
  output logic [CWP_W-1:0] cwp_q,
  output logic [CWP_W-1:0] depth_q,
  output logic             ovf_q,
  output logic             unf_q
);
  localparam logic [CWP_W-1:0] TOP = CWP_W'(NWIN - 1);

  function automatic logic [CWP_W-1:0] f_inc(input logic [CWP_W-1:0] v);
    return (v == TOP) ? '0 : v + 1'b1;
  endfunction

  function automatic logic [CWP_W-1:0] f_dec(input logic [CWP_W-1:0] v);
    return (v == '0) ? TOP : v - 1'b1;
  endfunction

  always_comb begin
    case ({call_i, ret_i})
      2'b10:   win_move = (depth_q == TOP) ? WM_OVF : WM_CALL;
      2'b01:   win_move = (depth_q == '0)  ? WM_UNF : WM_RET;
      default: win_move = WM_HOLD;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cwp_q   <= '0;
      depth_q <= '0;
      ovf_q   <= 1'b0;
      unf_q   <= 1'b0;
    end else begin
      ovf_q <= (win_move == WM_OVF);
      unf_q <= (win_move == WM_UNF);
      case (win_move)
        WM_CALL: begin
          cwp_q   <= f_inc(cwp_q);
          depth_q <= depth_q + 1'b1;
        end
        WM_RET: begin
          cwp_q   <= f_dec(cwp_q);
          depth_q <= depth_q - 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/rwin_store.sv
module rwin_store #(
  parameter int NPHYS  = 74,
  parameter int PHYS_W = 7,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PHYS_W-1:0] wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [PHYS_W-1:0] rd_a_idx,
  input  logic [PHYS_W-1:0] rd_b_idx,
  output logic [DATA_W-1:0] rd_a_data,
  output logic [DATA_W-1:0] rd_b_data
);
  logic [DATA_W-1:0] regs [NPHYS];

  for (genvar g = 0; g < NPHYS; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        regs[g] <= '0;
      else if (wr_en && (wr_idx == PHYS_W'(g)))
        regs[g] <= wr_data;
    end
  end

  assign rd_a_data = (int'(rd_a_idx) < NPHYS) ? regs[rd_a_idx] : '0;
  assign rd_b_data = (int'(rd_b_idx) < NPHYS) ? regs[rd_b_idx] : '0;
endmodule

// File: rtl/rwin_file.sv
module rwin_file
  import rwin_pkg::*;
#(
  parameter int NGLOB  = RW_NGLOB,
  parameter int NLOC   = RW_NLOC,
  parameter int NCOM   = RW_NCOM,
  parameter int NWIN   = RW_NWIN,
  parameter int DATA_W = RW_DATA_W,
  localparam int NPHYS  = (NLOC + NCOM) * NWIN + NGLOB,
  localparam int NLREG  = NLOC + 2 * NCOM + NGLOB,
  localparam int LREG_W = $clog2(NLREG),
  localparam int PHYS_W = $clog2(NPHYS),
  localparam int CWP_W  = $clog2(NWIN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              call_i,
  input  logic              ret_i,
  input  logic [LREG_W-1:0] rd_a_addr,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [LREG_W-1:0] rd_b_addr,
  output logic [DATA_W-1:0] rd_b_data,
  input  logic              wr_en,
  input  logic [LREG_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [CWP_W-1:0]  cwp_o,
  output logic [CWP_W-1:0]  depth_o,
  output logic              ovf_o,
  output logic              unf_o
);
  wmove_e            win_move;
  logic [CWP_W-1:0]  cwp_q;
  logic [CWP_W-1:0]  depth_q;
  logic              ovf_q;
  logic              unf_q;
  logic [PHYS_W-1:0] rd_a_phys;
  logic [PHYS_W-1:0] rd_b_phys;
  logic [PHYS_W-1:0] wr_phys;

  rwin_ctrl #(.NWIN(NWIN), .CWP_W(CWP_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .call_i(call_i), .ret_i(ret_i),
    .win_move(win_move), .cwp_q(cwp_q), .depth_q(depth_q),
    .ovf_q(ovf_q), .unf_q(unf_q)
  );

  rwin_xlate #(.NGLOB(NGLOB), .NLOC(NLOC), .NCOM(NCOM), .NWIN(NWIN),
               .LREG_W(LREG_W), .PHYS_W(PHYS_W), .CWP_W(CWP_W)) u_xl_a (
    .cwp(cwp_q), .lreg(rd_a_addr), .phys(rd_a_phys)
  );

  rwin_xlate #(.NGLOB(NGLOB), .NLOC(NLOC), .NCOM(NCOM), .NWIN(NWIN),
               .LREG_W(LREG_W), .PHYS_W(PHYS_W), .CWP_W(CWP_W)) u_xl_b (
    .cwp(cwp_q), .lreg(rd_b_addr), .phys(rd_b_phys)
  );

  // Write side uses the pointer held before the edge.
  rwin_xlate #(.NGLOB(NGLOB), .NLOC(NLOC), .NCOM(NCOM), .NWIN(NWIN),
               .LREG_W(LREG_W), .PHYS_W(PHYS_W), .CWP_W(CWP_W)) u_xl_w (
    .cwp(cwp_q), .lreg(wr_addr), .phys(wr_phys)
  );

  rwin_store #(.NPHYS(NPHYS), .PHYS_W(PHYS_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_phys),
    .wr_data(wr_data), .rd_a_idx(rd_a_phys), .rd_b_idx(rd_b_phys),
    .rd_a_data(rd_a_data), .rd_b_data(rd_b_data)
  );

  assign cwp_o   = cwp_q;
  assign depth_o = depth_q;
  assign ovf_o   = ovf_q;
  assign unf_o   = unf_q;
endmodule

// File: rtl/rwin_file_chk.sv
module rwin_file_chk
  import rwin_pkg::*;
#(
  parameter int NWIN   = 4,
  parameter int NPHYS  = 74,
  parameter int CWP_W  = 2,
  parameter int PHYS_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              call_i,
  input logic              ret_i,
  input logic              wr_en,
  input wmove_e            win_move,
  input logic [CWP_W-1:0]  cwp_q,
  input logic [CWP_W-1:0]  depth_q,
  input logic              ovf_q,
  input logic              unf_q,
  input logic [PHYS_W-1:0] wr_phys
);
  localparam logic [CWP_W-1:0] TOP = CWP_W'(NWIN - 1);

  // R5: pointer advances with wrap, depth grows
  p_call_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (win_move == WM_CALL) |=>
      (cwp_q == (($past(cwp_q) == TOP) ? '0 : $past(cwp_q) + 1'b1)) &&
      (depth_q == $past(depth_q) + 1'b1));

  // R5: pointer and depth move in lockstep from reset
  p_cwp_tracks_depth_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cwp_q == depth_q);

  // R6: return steps both back
  p_ret_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (win_move == WM_RET) |=>
      (cwp_q == (($past(cwp_q) == '0) ? TOP : $past(cwp_q) - 1'b1)) &&
      (depth_q == $past(depth_q) - 1'b1));

  // R7: refused call
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (call_i && !ret_i && depth_q == TOP) |=>
      ovf_q && !unf_q && $stable(cwp_q) && $stable(depth_q));

  // R7: overflow pulse only after a refused call
  p_ovf_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_q) |-> $past(call_i) && !$past(ret_i));

  // R8: refused return
  p_no_underflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_i && !call_i && depth_q == '0) |=>
      unf_q && !ovf_q && $stable(cwp_q) && $stable(depth_q));

  // R10: simultaneous strobes do nothing
  p_both_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (call_i && ret_i) |=>
      $stable(cwp_q) && $stable(depth_q) && !ovf_q && !unf_q);

  // R9: write target stays inside the physical file
  p_wr_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (int'(wr_phys) < NPHYS));

  // R7, R8: flags never together
  p_flags_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ovf_q, unf_q}));
endmodule

bind rwin_file rwin_file_chk #(
  .NWIN(NWIN), .NPHYS(NPHYS), .CWP_W(CWP_W), .PHYS_W(PHYS_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .call_i(call_i), .ret_i(ret_i), .wr_en(wr_en),
  .win_move(win_move), .cwp_q(cwp_q), .depth_q(depth_q),
  .ovf_q(ovf_q), .unf_q(unf_q), .wr_phys(wr_phys)
);

// File: tb/rwin_file_bench.sv
module rwin_file_bench;
  localparam int PERIOD = 10;

  typedef struct packed {
    logic [7:0]  req;
    logic        call;
    logic        ret;
    logic        we;
    logic [4:0]  wa;
    logic [31:0] wd;
    logic [4:0]  ra;
    logic [4:0]  rb;
    logic [31:0] ea;
    logic [31:0] eb;
    logic [1:0]  ecwp;
    logic [1:0]  edep;
    logic        eov;
    logic        eun;
  } vec_t;

  localparam int NV = 17;
  // Expected values are the state seen after the vector's rising edge.
  localparam vec_t VECS [NV] = '{
    // R2: global write at window 0
    '{8'd2,  1'b0,1'b0,1'b1, 5'd3,  32'h0A03, 5'd3,  5'd16, 32'h0A03, 32'h0,    2'd0,2'd0,1'b0,1'b0},
    // R11: local write, two ports
    '{8'd11, 1'b0,1'b0,1'b1, 5'd16, 32'h0B16, 5'd16, 5'd3,  32'h0B16, 32'h0A03, 2'd0,2'd0,1'b0,1'b0},
    // R4: outgoing of window 0 seen as incoming of window 1
    '{8'd4,  1'b1,1'b0,1'b1, 5'd27, 32'h0C27, 5'd11, 5'd3,  32'h0C27, 32'h0A03, 2'd1,2'd1,1'b0,1'b0},
    // R3: locals and outgoing of window 1 are fresh
    '{8'd3,  1'b0,1'b0,1'b0, 5'd0,  32'h0,    5'd16, 5'd27, 32'h0,    32'h0,    2'd1,2'd1,1'b0,1'b0},
    // R3: window 1 local
    '{8'd3,  1'b0,1'b0,1'b1, 5'd16, 32'h0D16, 5'd16, 5'd11, 32'h0D16, 32'h0C27, 2'd1,2'd1,1'b0,1'b0},
    // R9: result written into incoming set while returning
    '{8'd9,  1'b0,1'b1,1'b1, 5'd12, 32'h0E12, 5'd28, 5'd16, 32'h0E12, 32'h0B16, 2'd0,2'd0,1'b0,1'b0},
    // R5: call back into window 1
    '{8'd5,  1'b1,1'b0,1'b0, 5'd0,  32'h0,    5'd16, 5'd12, 32'h0D16, 32'h0E12, 2'd1,2'd1,1'b0,1'b0},
    // R9: write with call from window 1
    '{8'd9,  1'b1,1'b0,1'b1, 5'd30, 32'h0F30, 5'd14, 5'd3,  32'h0F30, 32'h0A03, 2'd2,2'd2,1'b0,1'b0},
    // R9: write with call from window 2
    '{8'd9,  1'b1,1'b0,1'b1, 5'd29, 32'h1029, 5'd13, 5'd16, 32'h1029, 32'h0,    2'd3,2'd3,1'b0,1'b0},
    // R2: global still visible in window 3
    '{8'd2,  1'b0,1'b0,1'b1, 5'd31, 32'h1131, 5'd31, 5'd3,  32'h1131, 32'h0A03, 2'd3,2'd3,1'b0,1'b0},
    // R7: call at full depth refused
    '{8'd7,  1'b1,1'b0,1'b0, 5'd0,  32'h0,    5'd16, 5'd31, 32'h0,    32'h1131, 2'd3,2'd3,1'b1,1'b0},
    // R6: return to window 2
    '{8'd6,  1'b0,1'b1,1'b0, 5'd0,  32'h0,    5'd30, 5'd14, 32'h0,    32'h0F30, 2'd2,2'd2,1'b0,1'b0},
    // R6: return to window 1
    '{8'd6,  1'b0,1'b1,1'b0, 5'd0,  32'h0,    5'd16, 5'd30, 32'h0D16, 32'h0F30, 2'd1,2'd1,1'b0,1'b0},
    // R4: wrap, window 3 outgoing is window 0 incoming
    '{8'd4,  1'b0,1'b1,1'b0, 5'd0,  32'h0,    5'd15, 5'd16, 32'h1131, 32'h0B16, 2'd0,2'd0,1'b0,1'b0},
    // R8: return at depth 0 refused
    '{8'd8,  1'b0,1'b1,1'b0, 5'd0,  32'h0,    5'd3,  5'd28, 32'h0A03, 32'h0E12, 2'd0,2'd0,1'b0,1'b1},
    // R10: call and return together
    '{8'd10, 1'b1,1'b1,1'b0, 5'd0,  32'h0,    5'd27, 5'd3,  32'h0C27, 32'h0A03, 2'd0,2'd0,1'b0,1'b0},
    // R12: disabled write changes nothing
    '{8'd12, 1'b0,1'b0,1'b0, 5'd3,  32'hDEAD, 5'd3,  5'd3,  32'h0A03, 32'h0A03, 2'd0,2'd0,1'b0,1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        call_i = 1'b0;
  logic        ret_i = 1'b0;
  logic [4:0]  rd_a_addr = '0;
  logic [31:0] rd_a_data;
  logic [4:0]  rd_b_addr = '0;
  logic [31:0] rd_b_data;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  cwp_o;
  logic [1:0]  depth_o;
  logic        ovf_o;
  logic        unf_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  rwin_file u_rwin_file (
    .clk(clk), .rst_n(rst_n), .call_i(call_i), .ret_i(ret_i),
    .rd_a_addr(rd_a_addr), .rd_a_data(rd_a_data),
    .rd_b_addr(rd_b_addr), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cwp_o(cwp_o), .depth_o(depth_o), .ovf_o(ovf_o), .unf_o(unf_o)
  );

  always #(PERIOD / 2) clk = ~clk;

  task automatic check_state(input string tag, input logic [31:0] ea,
                             input logic [31:0] eb, input logic [1:0] ec,
                             input logic [1:0] ed, input logic eo, input logic eu);
    n_chk++;
    if (rd_a_data !== ea || rd_b_data !== eb || cwp_o !== ec ||
        depth_o !== ed || ovf_o !== eo || unf_o !== eu) begin
      n_fail++;
      $display("FAIL %s: got a=%h b=%h cwp=%0d dep=%0d ovf=%b unf=%b exp a=%h b=%h cwp=%0d dep=%0d ovf=%b unf=%b",
               tag, rd_a_data, rd_b_data, cwp_o, depth_o, ovf_o, unf_o,
               ea, eb, ec, ed, eo, eu);
    end
  endtask

  initial begin
    #(PERIOD * 2000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired, all requirements unchecked");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    rd_a_addr = 5'd3;
    rd_b_addr = 5'd16;
    repeat (3) @(negedge clk);
    check_state("R1 during reset", 32'h0, 32'h0, 2'd0, 2'd0, 1'b0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check_state("R1 after release", 32'h0, 32'h0, 2'd0, 2'd0, 1'b0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      call_i    = VECS[i].call;
      ret_i     = VECS[i].ret;
      wr_en     = VECS[i].we;
      wr_addr   = VECS[i].wa;
      wr_data   = VECS[i].wd;
      rd_a_addr = VECS[i].ra;
      rd_b_addr = VECS[i].rb;
      @(negedge clk);
      check_state($sformatf("R%0d vector %0d", VECS[i].req, i),
                  VECS[i].ea, VECS[i].eb, VECS[i].ecwp, VECS[i].edep,
                  VECS[i].eov, VECS[i].eun);
    end

    // R7: overflow pulse lasts one cycle; R8 likewise for underflow
    call_i = 1'b0; ret_i = 1'b0; wr_en = 1'b0;
    rd_a_addr = 5'd3; rd_b_addr = 5'd16;
    @(negedge clk);
    check_state("R8 flag cleared", 32'h0A03, 32'h0B16, 2'd0, 2'd0, 1'b0, 1'b0);

    // R1: reset mid-run from window 1 clears everything
    call_i = 1'b1;
    @(negedge clk);
    call_i = 1'b0;
    check_state("R5 call before reset", 32'h0A03, 32'h0D16, 2'd1, 2'd1, 1'b0, 1'b0);
    rst_n = 1'b0;
    #1;
    check_state("R1 mid-run reset", 32'h0, 32'h0, 2'd0, 2'd0, 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_state("R1 after second release", 32'h0, 32'h0, 2'd0, 2'd0, 1'b0, 1'b0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule